// File: doc/BRIEF.md
# Ping reset command detector

This block sits on the receive byte path of a network port. It sees only the payload bytes of ICMP echo requests. The upstream parser marks each byte with a valid flag, the first payload byte with a start flag and the final byte with a last flag. The block scans each payload for a 32-bit unlock word followed by a 32-bit command word. When both are correct, it raises a single-cycle action pulse. The pulse can request an FPGA reboot, a cold reset or a warm reset, or it can release the transmit lock of one channel.

The block has no dependency on any other logic in the device. It is a small state machine with a byte counter and two holding registers. An operator can therefore use an ordinary ping carrying a special payload to recover a device whose other logic has stopped. Header parsing for Ethernet, IP and ICMP is done upstream.

Top module: `ping_reset_detector`

## Requirements
- R1: While reset is asserted and after it is released, with no payload received, all action outputs are low.
- R2: A payload is accepted only if its bytes 0 to 3 are 0xAB, 0xAD, 0x1D and 0xEA, in that order. Byte 0 is the valid byte that carries the start flag.
- R3: If byte 4 is 0xA5, `reboot_o` pulses. If byte 4 is 0xB4, `cold_rst_o` pulses. If byte 4 is 0xC3, `warm_rst_o` pulses. The pulse lasts one cycle and appears in the cycle after the clock edge that accepts byte 7.
- R4: If byte 4 is 0xD2, byte 5 is a channel number c. Bit c of `clr_lock_o` pulses alone, with the same timing as R3.
- R5: A 0xD2 command whose channel byte is NUM_CH or greater produces no pulse.
- R6: A magic mismatch or an unknown command byte produces no action. Every later byte is ignored until the next start flag, even if those bytes contain the full pattern.
- R7: If the last flag arrives on any byte before byte 7, no action is produced.
- R8: A payload produces at most one action. Bytes after byte 7, and valid bytes that arrive without a preceding start flag, are ignored.
- R9: A valid byte with the start flag restarts parsing at byte 0, even in the middle of a payload.
- R10: Cycles in which `rx_valid_i` is low do not count as bytes. Bytes 6 and 7, and byte 5 for commands other than 0xD2, take any value.
- R11: At most one action output bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Payload byte |
| rx_valid_i | input | 1 | Byte qualifier |
| rx_start_i | input | 1 | Marks the first payload byte |
| rx_last_i | input | 1 | Marks the final payload byte |
| reboot_o | output | 1 | Reboot request pulse |
| cold_rst_o | output | 1 | Cold reset request pulse |
| warm_rst_o | output | 1 | Warm reset request pulse |
| clr_lock_o | output | NUM_CH | One-hot pulse that releases a channel's transmit lock |

## Verification
If the byte position counter is off by one, correct payloads stop firing, or they fire one byte early or late. The bench catches this at the first payload because it records which accepted byte preceded each pulse. A state that fails to leave the parsing state after a mismatch, a last flag or byte 7 shows up as a spurious pulse. That pulse appears within eight valid bytes, on repeated patterns or on trailing bytes sent without a start flag. A wrong command or channel register gives the wrong output bit in the same cycle the pulse is due.

// File: rtl/pod_pkg.sv
package pod_pkg;
  localparam int unsigned WORD_BYTES  = 4;
  localparam int unsigned FRAME_BYTES = 2 * WORD_BYTES;
  localparam logic [8*WORD_BYTES-1:0] MAGIC_WORD = 32'hABAD_1DEA;

  localparam logic [7:0] OP_REBOOT = 8'hA5;
  localparam logic [7:0] OP_COLD   = 8'hB4;
  localparam logic [7:0] OP_WARM   = 8'hC3;
  localparam logic [7:0] OP_UNLOCK = 8'hD2;

  typedef enum logic {ST_WAIT, ST_RUN} scan_state_e;

  function automatic logic op_known(input logic [7:0] op);
    case (op)
      OP_REBOOT, OP_COLD, OP_WARM, OP_UNLOCK: return 1'b1;
      default:                                return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pod_tracker.sv
module pod_tracker
  import pod_pkg::*;
#(
  parameter int unsigned NBYTES = 8,
  localparam int unsigned POS_W = $clog2(NBYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             start_i,
  input  logic             last_i,
  input  logic             abort_i,
  output logic             take_o,
  output logic [POS_W-1:0] pos_o,
  output logic             done_o
);
  scan_state_e      st_q;
  logic [POS_W-1:0] idx_q;
  logic             at_end;

  // start wins over any payload in progress
  assign take_o = valid_i & (start_i | (st_q == ST_RUN));
  assign pos_o  = start_i ? '0 : idx_q;
  assign at_end = (pos_o == POS_W'(NBYTES - 1));
  assign done_o = take_o & ~abort_i & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_WAIT;
      idx_q <= '0;
    end else if (take_o) begin
      idx_q <= pos_o + 1'b1;
      if (abort_i || last_i || at_end) st_q <= ST_WAIT;
      else                             st_q <= ST_RUN;
    end
  end

  AST_RUN_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == ST_RUN) |-> $past(valid_i && start_i)); // R9
endmodule

// File: rtl/pod_field_check.sv
module pod_field_check
  import pod_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned NBYTES = FRAME_BYTES,
  localparam int unsigned POS_W = $clog2(NBYTES),
  localparam int unsigned MW    = $clog2(WORD_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [7:0]       byte_i,
  output logic             bad_o,
  output logic [7:0]       op_o,
  output logic [7:0]       chan_o
);
  localparam logic [POS_W-1:0] POS_OP   = POS_W'(WORD_BYTES);
  localparam logic [POS_W-1:0] POS_CHAN = POS_W'(WORD_BYTES + 1);

  logic [7:0] magic_b [WORD_BYTES];
  logic [7:0] op_q, chan_q;

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_magic
    assign magic_b[k] = MAGIC_WORD[8*(WORD_BYTES-1-k) +: 8];
  end

  always_comb begin
    bad_o = 1'b0;
    if (pos_i < POS_OP)        bad_o = (byte_i != magic_b[pos_i[MW-1:0]]);
    else if (pos_i == POS_OP)  bad_o = !op_known(byte_i);
    else if (pos_i == POS_CHAN)
      bad_o = (op_q == OP_UNLOCK) && (32'(byte_i) >= NUM_CH);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= '0;
      chan_q <= '0;
    end else if (take_i) begin
      if (pos_i == POS_OP)   op_q   <= byte_i;
      if (pos_i == POS_CHAN) chan_q <= byte_i;
    end
  end

  assign op_o   = op_q;
  assign chan_o = chan_q;
endmodule

// File: rtl/pod_action.sv
module pod_action
  import pod_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [7:0]        op_i,
  input  logic [7:0]        chan_i,
  output logic              reboot_o,
  output logic              cold_o,
  output logic              warm_o,
  output logic [NUM_CH-1:0] unlock_o
);
  logic any_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reboot_o <= 1'b0;
      cold_o   <= 1'b0;
      warm_o   <= 1'b0;
    end else begin
      reboot_o <= fire_i && (op_i == OP_REBOOT);
      cold_o   <= fire_i && (op_i == OP_COLD);
      warm_o   <= fire_i && (op_i == OP_WARM);
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_unlock
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) unlock_o[c] <= 1'b0;
      else         unlock_o[c] <= fire_i && (op_i == OP_UNLOCK) && (chan_i == 8'(c));
    end
  end

  assign any_act = reboot_o | cold_o | warm_o | (|unlock_o);

  AST_SINGLE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reboot_o, cold_o, warm_o, unlock_o})); // R11
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_act |=> !any_act); // R8
  AST_FIRE_TO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> any_act); // R3
  AST_OP_KNOWN_AT_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> op_known(op_i)); // R6
endmodule

// File: rtl/ping_reset_detector.sv
module ping_reset_detector
  import pod_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned POS_W = $clog2(FRAME_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  input  logic              rx_start_i,
  input  logic              rx_last_i,
  output logic              reboot_o,
  output logic              cold_rst_o,
  output logic              warm_rst_o,
  output logic [NUM_CH-1:0] clr_lock_o
);
  logic             take, bad, done;
  logic [POS_W-1:0] pos;
  logic [7:0]       op, chan;

  pod_tracker #(.NBYTES(FRAME_BYTES)) u_trk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(rx_valid_i),
    .start_i(rx_start_i),
    .last_i (rx_last_i),
    .abort_i(bad),
    .take_o (take),
    .pos_o  (pos),
    .done_o (done)
  );

  pod_field_check #(.NUM_CH(NUM_CH), .NBYTES(FRAME_BYTES)) u_chk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .take_i(take),
    .pos_i (pos),
    .byte_i(rx_data_i),
    .bad_o (bad),
    .op_o  (op),
    .chan_o(chan)
  );

  pod_action #(.NUM_CH(NUM_CH)) u_act (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (done),
    .op_i    (op),
    .chan_i  (chan),
    .reboot_o(reboot_o),
    .cold_o  (cold_rst_o),
    .warm_o  (warm_rst_o),
    .unlock_o(clr_lock_o)
  );

  AST_PULSE_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reboot_o | cold_rst_o | warm_rst_o | (|clr_lock_o)) |-> $past(rx_valid_i)); // R3
endmodule

// File: tb/sim_ping_reset_detector.sv
module sim_ping_reset_detector;
  localparam int unsigned NUM_CH = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        rx_data = '0;
  logic              rx_valid = 1'b0, rx_start = 1'b0, rx_last = 1'b0;
  logic              reboot, cold, warm;
  logic [NUM_CH-1:0] clr;

  ping_reset_detector #(.NUM_CH(NUM_CH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .rx_start_i(rx_start), .rx_last_i(rx_last), .reboot_o(reboot),
    .cold_rst_o(cold), .warm_rst_o(warm), .clr_lock_o(clr)
  );

  always #10 clk = ~clk; // 50 MHz

  int n_chk = 0, n_fail = 0;
  logic [7:0] pl [16];
  int pl_len;
  int acc, obs_cnt, obs_kind, obs_chan, obs_pos;
  int gap_pct = 0;

  function automatic logic [7:0] magic_byte(input int i);
    case (i)
      0: return 8'hAB;
      1: return 8'hAD;
      2: return 8'h1D;
      default: return 8'hEA;
    endcase
  endfunction

  // kind: 0 none, 1 reboot, 2 cold, 3 warm, 4 unlock
  function automatic int exp_kind(input bit with_start);
    if (!with_start || pl_len < 8) return 0;
    for (int i = 0; i < 4; i++) if (pl[i] != magic_byte(i)) return 0;
    case (pl[4])
      8'hA5: return 1;
      8'hB4: return 2;
      8'hC3: return 3;
      8'hD2: return (int'(pl[5]) < NUM_CH) ? 4 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic sample();
    if (reboot | cold | warm | (|clr)) begin
      obs_cnt++;
      obs_pos = acc;
      if ($countones({reboot, cold, warm, clr}) != 1) obs_kind = 9;
      else if (reboot) obs_kind = 1;
      else if (cold)   obs_kind = 2;
      else if (warm)   obs_kind = 3;
      else begin
        obs_kind = 4;
        for (int c = 0; c < NUM_CH; c++) if (clr[c]) obs_chan = c;
      end
    end
  endtask

  task automatic step(input logic v, input logic s, input logic l, input logic [7:0] d);
    @(negedge clk);
    sample();
    rx_valid = v; rx_start = s; rx_last = l; rx_data = d;
    if (v) acc++;
  endtask

  task automatic send(input bit with_start, input bit with_last);
    acc = 0; obs_cnt = 0; obs_kind = 0; obs_chan = -1; obs_pos = -1;
    for (int i = 0; i < pl_len; i++) begin
      while (($urandom % 100) < gap_pct) step(1'b0, 1'b0, 1'b0, 8'($urandom));
      step(1'b1, with_start && i == 0, with_last && i == pl_len - 1, pl[i]);
    end
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic check(input string req, input bit with_start);
    int e;
    bit ok;
    e = exp_kind(with_start);
    n_chk++;
    if (e == 0) ok = (obs_cnt == 0);
    else ok = (obs_cnt == 1) && (obs_kind == e) && (obs_pos == 8) &&
              (e != 4 || obs_chan == int'(pl[5]));
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: pulses=%0d kind=%0d pos=%0d chan=%0d, expected pulses=%0d kind=%0d pos=8 chan=%0d",
               req, obs_cnt, obs_kind, obs_pos, obs_chan, (e != 0), e, (e == 4) ? int'(pl[5]) : -1);
    end
  endtask

  task automatic load_frame(input logic [7:0] op, input logic [7:0] arg, input int len);
    pl_len = len;
    for (int i = 0; i < 16; i++) pl[i] = 8'($urandom);
    for (int i = 0; i < 4; i++) pl[i] = magic_byte(i);
    pl[4] = op;
    pl[5] = arg;
  endtask

  task automatic run(input string req, input bit with_start, input bit with_last);
    send(with_start, with_last);
    check(req, with_start);
  endtask

  initial begin
    #3000000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] ops [4];
    ops[0] = 8'hA5; ops[1] = 8'hB4; ops[2] = 8'hC3; ops[3] = 8'hD2;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    n_chk++;
    if ({reboot, cold, warm, clr} != '0) begin
      n_fail++; $display("FAIL R1: outputs=%0h during reset, expected 0", {reboot, cold, warm, clr});
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_chk++;
    if ({reboot, cold, warm, clr} != '0) begin
      n_fail++; $display("FAIL R1: outputs=%0h after reset, expected 0", {reboot, cold, warm, clr});
    end

    // R3: each reset command, exact 8-byte payload
    for (int k = 0; k < 3; k++) begin
      load_frame(ops[k], 8'h77, 8); run("R3", 1, 1);
    end
    // R4: every channel
    for (int c = 0; c < NUM_CH; c++) begin
      load_frame(8'hD2, 8'(c), 8); run("R4", 1, 1);
    end
    // R5: channel out of range
    load_frame(8'hD2, 8'(NUM_CH), 8); run("R5", 1, 1);
    load_frame(8'hD2, 8'hFF, 10);     run("R5", 1, 1);
    // R2: mismatch at each magic position
    for (int p = 0; p < 4; p++) begin
      load_frame(8'hC3, 8'h00, 8); pl[p] = pl[p] ^ 8'h10; run("R2", 1, 1);
    end
    // R6: unknown commands, and pattern reappearing after mismatch
    load_frame(8'h00, 8'h00, 8); run("R6", 1, 1);
    load_frame(8'hA4, 8'h00, 8); run("R6", 1, 1);
    pl_len = 9; pl[0] = 8'hAB;
    for (int i = 0; i < 4; i++) pl[i+1] = magic_byte(i);
    pl[5] = 8'hC3; pl[6] = 8'h00; pl[7] = 8'h00; pl[8] = 8'h00;
    run("R6", 1, 1);
    // R7: early last
    for (int n = 5; n < 8; n++) begin
      load_frame(8'hA5, 8'h00, n); run("R7", 1, 1);
    end
    // R8: pattern repeated twice in one payload gives one action
    load_frame(8'hB4, 8'h00, 16);
    for (int i = 0; i < 8; i++) pl[i+8] = pl[i];
    run("R8", 1, 1);
    // R8: full pattern without a start flag
    load_frame(8'hC3, 8'h00, 8); run("R8", 0, 1);
    // R9: abandoned partial payload, then restart
    load_frame(8'hA5, 8'h00, 5); run("R9", 1, 0);
    load_frame(8'hD2, 8'h03, 8); run("R9", 1, 1);
    // R10: gaps and don't-care bytes
    gap_pct = 40;
    load_frame(8'hC3, 8'hD2, 8); run("R10", 1, 1);
    load_frame(8'hD2, 8'h06, 12); run("R10", 1, 1);

    // random mix
    for (int t = 0; t < 400; t++) begin
      int r;
      gap_pct = ($urandom % 2) ? 25 : 0;
      r = $urandom % 6;
      load_frame(r < 4 ? ops[r] : (r == 4 ? 8'hD2 : 8'($urandom)),
                 8'($urandom % (NUM_CH + 4)), 4 + ($urandom % 12));
      if (($urandom % 5) == 0) pl[$urandom % 4] = 8'($urandom);
      run("R10", 1, 1);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule